// File: doc/BRIEF.md
# Watchdog Timer with Keyed Arm/Disarm

This block is a memory-mapped watchdog with a small word-addressed register bus. An up-counter advances on a slow tick enable, either on every tick or once every 2^N ticks when the prescaler is on. Software sets a load value and services the watchdog by writing the trigger register, which copies the load value into the counter. If the counter rolls over from all ones while the watchdog is armed, the block raises a one-cycle reset pulse and the counter restarts from the load value.

Arming and disarming are guarded by two-word key pairs written to the key register. A write that does not complete a valid pair sends the sequence checker back to idle and leaves the armed state unchanged. Writes to the control, load, trigger and key registers are posted into the slow domain. That crossing is modelled as a fixed number of slow ticks. Each of these four registers has a busy flag that software can read, and a write to a register whose flag is still set is dropped. A posted value takes effect only when its flag clears.

Top module: `wdt_keyed`

## Requirements
- R1: Word addresses are 0 revision, 1 control, 2 counter, 3 load, 4 trigger, 5 key, 6 pending. After reset the watchdog is armed, and control, load, counter and all pending flags read zero.
- R2: Bits 7:0 of the revision register return the REV_CODE parameter. A write to that address has no effect.
- R3: Each pending bit sets on the cycle after its register is written and clears after exactly PEND_TICKS slow ticks. The bits are control at 0, load at 2, trigger at 3 and key at 4.
- R4: A write to a register whose pending flag is set is ignored.
- R5: A posted control or load value is not visible until its pending flag clears. The old value reads back while the flag is set.
- R6: When a trigger write's flag clears, the counter reads the load value one cycle later.
- R7: With the prescaler off (control bit 5 = 0), the counter advances by one on each slow tick.
- R8: With control bit 5 = 1, the counter advances once every 2^P slow ticks, where P is control bits 4:2. Control bits 1:0 read as zero. A reload or a control update restarts the prescale count.
- R9: Writing key 0xBBBB and then 0x4444 arms the watchdog.
- R10: Writing key 0xAAAA and then 0x5555 disarms the watchdog.
- R11: A key write that does not complete a valid pair returns the checker to idle and leaves the armed state unchanged.
- R12: A step taken while the counter holds all ones reloads the counter from the load register. If the watchdog is armed, the same step raises `wdt_rst` for one cycle. If it is disarmed, no pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow time-base enable, one cycle wide |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| wdt_rst | output | 1 | One-cycle reset request on expiry while armed |

## Verification
A pending bit reads back on the cycle after the bus write. It clears at the edge that consumes the PEND_TICKS-th slow tick. The committed value becomes visible one cycle later, and a trigger's reload shows in the counter on that same following cycle. Counter steps and the expiry pulse are visible on the cycle after the tick that causes them. The bench drives every clock through one task, which counts the ticks the design has actually consumed and any reset pulses. Each check waits a counted number of consumed ticks, or polls the pending register until the flag drops, and then samples on the falling edge.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam int ADDR_W = 3;
  localparam int NSLOT  = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_REV   = 3'd0,
    RA_CTRL  = 3'd1,
    RA_COUNT = 3'd2,
    RA_LOAD  = 3'd3,
    RA_TRIG  = 3'd4,
    RA_KEY   = 3'd5,
    RA_PEND  = 3'd6
  } reg_addr_e;

  localparam logic [15:0] KEY_ARM_A = 16'hBBBB;
  localparam logic [15:0] KEY_ARM_B = 16'h4444;
  localparam logic [15:0] KEY_DIS_A = 16'hAAAA;
  localparam logic [15:0] KEY_DIS_B = 16'h5555;

  typedef enum logic [1:0] {
    KS_IDLE     = 2'd0,
    KS_ARM_HALF = 2'd1,
    KS_DIS_HALF = 2'd2
  } key_state_e;

  // posting slot index -> register address
  function automatic reg_addr_e slot_addr(input int s);
    case (s)
      0:       return RA_CTRL;
      1:       return RA_LOAD;
      2:       return RA_TRIG;
      default: return RA_KEY;
    endcase
  endfunction

  // posting slot index -> bit in the pending register
  function automatic int slot_pbit(input int s);
    case (s)
      0:       return 0;
      1:       return 2;
      2:       return 3;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/wdt_post.sv
`timescale 1ns/1ps
module wdt_post #(
  parameter int DW  = 32,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          commit,
  output logic [DW-1:0] cdata
);
  localparam int LCW = $clog2(LAT + 1);

  logic          busy_q, busy_d;
  logic          commit_q, commit_d;
  logic [LCW-1:0] lat_q, lat_d;
  logic [DW-1:0] data_q, data_d;

  always_comb begin
    busy_d   = busy_q;
    lat_d    = lat_q;
    data_d   = data_q;
    commit_d = 1'b0;
    if (wr && !busy_q) begin
      busy_d = 1'b1;
      lat_d  = LCW'(LAT);
      data_d = wdata;
    end else if (busy_q && tick) begin
      if (lat_q == LCW'(1)) begin
        busy_d   = 1'b0;
        commit_d = 1'b1;
      end else begin
        lat_d = lat_q - LCW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      commit_q <= 1'b0;
      lat_q    <= '0;
      data_q   <= '0;
    end else begin
      busy_q   <= busy_d;
      commit_q <= commit_d;
      lat_q    <= lat_d;
      data_q   <= data_d;
    end
  end

  assign busy   = busy_q;
  assign commit = commit_q;
  assign cdata  = data_q;

  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && busy_q) |=> $stable(data_q)); // R4
  AST_COMMIT_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> (!busy_q && $past(busy_q) && $past(tick))); // R3
endmodule

// File: rtl/wdt_keyseq.sv
`timescale 1ns/1ps
module wdt_keyseq
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        commit,
  input  logic [15:0] key,
  output logic        armed
);
  key_state_e st_q, st_d;
  logic       armed_q, armed_d;

  always_comb begin
    st_d    = st_q;
    armed_d = armed_q;
    if (commit) begin
      st_d = KS_IDLE;
      case (st_q)
        KS_IDLE: begin
          if (key == KEY_ARM_A)      st_d = KS_ARM_HALF;
          else if (key == KEY_DIS_A) st_d = KS_DIS_HALF;
        end
        KS_ARM_HALF: if (key == KEY_ARM_B) armed_d = 1'b1;
        KS_DIS_HALF: if (key == KEY_DIS_B) armed_d = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= KS_IDLE;
      armed_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      armed_q <= armed_d;
    end
  end

  assign armed = armed_q;

  AST_ARM_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(commit && key == KEY_ARM_B)); // R9
  AST_DISARM_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed_q) |-> $past(commit && key == KEY_DIS_B)); // R10
endmodule

// File: rtl/wdt_count.sv
`timescale 1ns/1ps
module wdt_count #(
  parameter int CNT_W = 32,
  parameter int PTV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             pre_en,
  input  logic [PTV_W-1:0] ptv,
  input  logic             restart,
  input  logic             reload,
  input  logic [CNT_W-1:0] load,
  input  logic             armed,
  output logic [CNT_W-1:0] cnt,
  output logic             bite
);
  localparam int PRE_W = (1 << PTV_W) - 1;

  logic [PRE_W-1:0] pre_q, pre_d, pre_lim;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             bite_q, bite_d;
  logic             pre_last, step, at_max;

  assign pre_lim  = ~({PRE_W{1'b1}} << ptv);
  assign pre_last = !pre_en || (pre_q == pre_lim);
  assign step     = tick && pre_last;
  assign at_max   = &cnt_q;

  always_comb begin
    pre_d  = pre_q;
    cnt_d  = cnt_q;
    bite_d = 1'b0;
    if (reload || restart) begin
      pre_d = '0;
    end else if (tick) begin
      pre_d = pre_last ? '0 : pre_q + PRE_W'(1);
    end
    if (reload) begin
      cnt_d = load;
    end else if (step) begin
      if (at_max) begin
        cnt_d  = load;
        bite_d = armed;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      bite_q <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      cnt_q  <= cnt_d;
      bite_q <= bite_d;
    end
  end

  assign cnt  = cnt_q;
  assign bite = bite_q;

  AST_BITE_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    bite_q |-> ($past(armed) && $past(tick))); // R12
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    bite_q |-> (cnt_q == $past(load))); // R12
endmodule

// File: rtl/wdt_keyed.sv
`timescale 1ns/1ps
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          CNT_W      = 32,
  parameter int          PEND_TICKS = 2,
  parameter logic [7:0]  REV_CODE   = 8'h21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_rst
);
  localparam int PTV_W = 3;

  // asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  logic [NSLOT-1:0]  slot_wr, slot_busy, slot_commit;
  logic [DATA_W-1:0] slot_data [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign slot_wr[g] = bus_we && (bus_addr == slot_addr(g));
    wdt_post #(.DW(DATA_W), .LAT(PEND_TICKS)) u_post (
      .clk    (clk),
      .rst_n  (rst_s_n),
      .tick   (tick),
      .wr     (slot_wr[g]),
      .wdata  (bus_wdata),
      .busy   (slot_busy[g]),
      .commit (slot_commit[g]),
      .cdata  (slot_data[g])
    );
  end

  logic             pre_en_q, pre_en_d;
  logic [PTV_W-1:0] ptv_q, ptv_d;
  logic [CNT_W-1:0] load_q, load_d;

  always_comb begin
    pre_en_d = pre_en_q;
    ptv_d    = ptv_q;
    load_d   = load_q;
    if (slot_commit[0]) begin
      pre_en_d = slot_data[0][5];
      ptv_d    = slot_data[0][4:2];
    end
    if (slot_commit[1]) load_d = slot_data[1][CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      pre_en_q <= 1'b0;
      ptv_q    <= '0;
      load_q   <= '0;
    end else begin
      pre_en_q <= pre_en_d;
      ptv_q    <= ptv_d;
      load_q   <= load_d;
    end
  end

  logic armed;
  wdt_keyseq u_key (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .commit (slot_commit[3]),
    .key    (slot_data[3][15:0]),
    .armed  (armed)
  );

  logic [CNT_W-1:0] cnt;
  wdt_count #(.CNT_W(CNT_W), .PTV_W(PTV_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .tick    (tick),
    .pre_en  (pre_en_q),
    .ptv     (ptv_q),
    .restart (slot_commit[0]),
    .reload  (slot_commit[2]),
    .load    (load_q),
    .armed   (armed),
    .cnt     (cnt),
    .bite    (wdt_rst)
  );

  logic [DATA_W-1:0] pend_w;
  always_comb begin
    pend_w = '0;
    for (int s = 0; s < NSLOT; s++) pend_w[slot_pbit(s)] = slot_busy[s];
  end

  always_comb begin
    case (bus_addr)
      RA_REV:   bus_rdata = DATA_W'(REV_CODE);
      RA_CTRL:  bus_rdata = DATA_W'({pre_en_q, ptv_q, 2'b00});
      RA_COUNT: bus_rdata = DATA_W'(cnt);
      RA_LOAD:  bus_rdata = DATA_W'(load_q);
      RA_PEND:  bus_rdata = pend_w;
      default:  bus_rdata = '0;
    endcase
  end

  wire unused_slot_bits = ^{slot_data[0], slot_data[1], slot_data[2], slot_data[3]};

  AST_PEND_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_we && bus_addr == RA_LOAD) |=> slot_busy[1]); // R3
endmodule

// File: tb/wdt_keyed_tb.sv
`timescale 1ns/1ps
module wdt_keyed_tb;
  localparam int         CW   = 12;
  localparam int         LAT  = 2;
  localparam logic [7:0] REVC = 8'h21;
  localparam int         MAXV = (1 << CW) - 1;
  localparam logic [2:0] A_REV = 3'd0, A_CTRL = 3'd1, A_CNT = 3'd2, A_LOAD = 3'd3,
                         A_TRIG = 3'd4, A_KEY = 3'd5, A_PEND = 3'd6;

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  wire  [31:0] bus_rdata;
  wire         wdt_rst;

  wdt_keyed #(.DATA_W(32), .CNT_W(CW), .PEND_TICKS(LAT), .REV_CODE(REVC)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst(wdt_rst)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0, consumed = 0, pulses = 0, phase = 0;
  bit tick_on = 1'b0;

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic cycle();
    @(negedge clk);
    if (tick) consumed++;
    if (wdt_rst) pulses++;
    if (tick_on) begin
      tick = (phase == 2);
      phase = (phase + 1) % 3;
    end else tick = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    cycle();
    bus_we = 1'b0;
  endtask

  function automatic int pbit(input logic [2:0] a);
    case (a)
      A_CTRL:  return 0;
      A_LOAD:  return 2;
      A_TRIG:  return 3;
      default: return 4;
    endcase
  endfunction

  task automatic wait_clear(input logic [2:0] a);
    logic [31:0] v;
    rd(A_PEND, v);
    while (v[pbit(a)]) begin
      cycle();
      rd(A_PEND, v);
    end
  endtask

  task automatic wr_commit(input logic [2:0] a, input logic [31:0] d);
    wr(a, d);
    wait_clear(a);
    cycle();
    cycle();
  endtask

  // leaves the bench on the falling edge where the reloaded count is visible
  task automatic reload_exact();
    wr(A_TRIG, 32'd1);
    wait_clear(A_TRIG);
    cycle();
  endtask

  task automatic wait_ticks(input int n);
    int t0;
    t0 = consumed;
    while (consumed < t0 + n) cycle();
  endtask

  function automatic int exp_count(input int ld, input bit en, input int p, input int n);
    return en ? ld + (n >> p) : ld + n;
  endfunction

  task automatic do_wrap(input bit exp_pulse, input string tag);
    logic [31:0] v;
    int p0;
    wr_commit(A_LOAD, MAXV - 2);
    reload_exact();
    p0 = pulses;
    wait_ticks(2);
    rd(A_CNT, v);
    chk({tag, " count at all ones"}, v, MAXV);
    wait_ticks(1);
    chk({tag, " R12 pulse count on wrap"}, pulses - p0, exp_pulse);
    rd(A_CNT, v);
    chk({tag, " R12 reload on wrap"}, v, MAXV - 2);
    cycle();
    chk({tag, " R12 pulse one cycle"}, wdt_rst, 1'b0);
  endtask

  initial begin
    logic [31:0] v;
    int t0, p0;
    repeat (3) cycle();
    rst_n = 1'b1;
    repeat (3) cycle();

    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_LOAD, v); chk("R1 load", v, 0);
    rd(A_PEND, v); chk("R1 pend", v, 0);
    rd(A_CNT, v);  chk("R1 count", v, 0);
    chk("R1 wdt_rst", wdt_rst, 0);
    rd(A_REV, v);  chk("R2 rev", v[7:0], REVC);

    // R1 armed after reset: counter runs from zero and bites
    tick_on = 1'b1;
    p0 = pulses;
    wait_ticks(MAXV);
    rd(A_CNT, v); chk("R7 count before wrap", v, MAXV);
    chk("R1 no early pulse", pulses - p0, 0);
    wait_ticks(1);
    chk("R1 armed out of reset", pulses - p0, 1);
    rd(A_CNT, v); chk("R12 reload zero", v, 0);

    // R2 write to revision ignored
    wr(A_REV, 32'h0);
    cycle();
    rd(A_REV, v); chk("R2 rev after write", v[7:0], REVC);

    // R3/R4/R5 posting of the load register
    wr(A_LOAD, 32'd100);
    t0 = consumed;
    rd(A_PEND, v); chk("R3 load pending bit2", v, 32'h4);
    rd(A_LOAD, v); chk("R5 old load while pending", v, 0);
    wr(A_LOAD, 32'd200);
    while (consumed < t0 + LAT - 1) cycle();
    rd(A_PEND, v); chk("R3 still pending", v[2], 1'b1);
    while (consumed < t0 + LAT) cycle();
    rd(A_PEND, v); chk("R3 clear after latency", v, 0);
    cycle();
    rd(A_LOAD, v); chk("R4 second write dropped", v, 100);

    wr(A_CTRL, 32'h0);
    rd(A_PEND, v); chk("R3 ctrl pending bit0", v, 32'h1);
    wait_clear(A_CTRL);
    wr(A_TRIG, 32'h1);
    rd(A_PEND, v); chk("R3 trig pending bit3", v, 32'h8);
    wait_clear(A_TRIG);
    wr(A_KEY, 32'h1234);
    rd(A_PEND, v); chk("R3 key pending bit4", v, 32'h10);
    wait_clear(A_KEY);
    cycle(); cycle();

    // R6/R7
    wr_commit(A_LOAD, 32'd300);
    reload_exact();
    rd(A_CNT, v); chk("R6 reload", v, 300);
    wait_ticks(5);
    rd(A_CNT, v); chk("R7 one per tick", v, 305);

    // R8 prescaler 2^2
    wr_commit(A_CTRL, 32'h2B);
    rd(A_CTRL, v); chk("R8 ctrl readback", v, 32'h28);
    reload_exact();
    rd(A_CNT, v); chk("R6 reload prescaled", v, 300);
    wait_ticks(3);
    rd(A_CNT, v); chk("R8 no step before 4", v, 300);
    wait_ticks(1);
    rd(A_CNT, v); chk("R8 step at 4", v, 301);
    wait_ticks(4);
    rd(A_CNT, v); chk("R8 step at 8", v, 302);
    wr_commit(A_CTRL, 32'h0);

    // key sequences
    wr_commit(A_KEY, 32'hAAAA);
    wr_commit(A_KEY, 32'h4444);
    do_wrap(1'b1, "R11 mixed pair keeps armed");
    wr_commit(A_KEY, 32'hAAAA);
    wr_commit(A_KEY, 32'h5555);
    do_wrap(1'b0, "R10 disarmed");
    wr_commit(A_KEY, 32'hBBBB);
    wr_commit(A_KEY, 32'hBBBB);
    wr_commit(A_KEY, 32'h4444);
    do_wrap(1'b0, "R11 broken pair keeps disarmed");
    wr_commit(A_KEY, 32'hBBBB);
    wr_commit(A_KEY, 32'h4444);
    do_wrap(1'b1, "R9 armed again");

    // random prescale and load settings
    void'($urandom(32'd7));
    for (int i = 0; i < 24; i++) begin
      bit en;
      int p, ld, n;
      en = 1'($urandom % 2);
      p  = int'($urandom % 8);
      ld = int'($urandom % (MAXV - 41));
      n  = int'($urandom % 41);
      if (i < 2) begin en = 1'b1; p = 0; end
      wr_commit(A_CTRL, {26'd0, en, 3'(p), 2'b00});
      wr_commit(A_LOAD, ld);
      reload_exact();
      wait_ticks(n);
      rd(A_CNT, v);
      chk(en ? "R8 random prescaled count" : "R7 random count", v, exp_count(ld, en, p, n));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule